// File: doc/BRIEF.md
# Passive SPI Bus Monitor

The block listens to an SPI bus without driving any line. It samples SCK, MOSI, MISO and the chip select on a fast system clock and passes each line through a two-flop synchronizer. From the synchronized levels it finds clock edges, assembles the full-duplex words and reports each finished word as a MOSI/MISO pair with a one-cycle valid strobe. With each word it gives the sample span from the first bit to the last bit, a flag for each lane that was present, and a framing warning.

Configuration inputs may change between transfers. They set clock polarity and phase, chip-select polarity, bit order, word length, and whether each of MOSI, MISO and chip select is wired. Chip-select activity produces its own strobes. Every change of level is reported with the old and the new level. An asserting change opens a transfer. A deasserting change closes it and reports how many words the transfer collected. The system clock must run at least four times faster than SCK.

Top module: `spi_bus_monitor`

## Requirements
- R1: The sampling edge depends on the pair (cfgCpol, cfgCpha). Pairs (0,0) and (1,1) capture on a rising SCK edge. Pairs (0,1) and (1,0) capture on a falling SCK edge.
- R2: With cfgCsActiveHigh=0 the chip select is active when csIn is 0. With cfgCsActiveHigh=1 it is active when csIn is 1. While chip select is present and inactive, SCK edges capture nothing.
- R3: Bits are numbered from 0 in the order they arrive. With cfgLsbFirst=0, bit n lands at word position size-1-n. With cfgLsbFirst=1, bit n lands at position n. MOSI and MISO are captured on the same edge.
- R4: A word is reported once size bits have been captured, and capture then starts a fresh word. The size is cfgWordSize. A value of 0 or a value above MAX_WORD (32 by default) is treated as MAX_WORD.
- R5: Any chip-select change, in either direction, discards a partly received word.
- R6: Every chip-select change gives a one-cycle csChangeValid with csOldLevel and csNewLevel set to the pin levels before and after the change. When cfgCsPresent=0 there are no chip-select or transfer strobes, and words are captured as if the bus were always selected.
- R7: An asserting change gives a one-cycle xferStart. A deasserting change gives a one-cycle xferEnd, with xferWordCount equal to the number of words completed since the matching start.
- R8: wordWarn is set on a word whose first bit was captured in the same cycle that the chip select went inactive. It is 0 for words framed wholly inside an active chip select, and always 0 when cfgCsPresent=0.
- R9: wordMosiPresent and wordMisoPresent copy cfgMosiPresent and cfgMisoPresent. An absent lane reports the value 0. No word is reported when both lanes are absent.
- R10: wordSpan equals the number of system-clock cycles from the capture of the first bit to the capture of the last bit, plus one. It saturates at its all-ones value.
- R11: wordValid rises exactly 3 clock edges after the SCK change that carries the last bit. It lasts one cycle, and the word outputs hold their values until the next word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sckIn | input | 1 | Bus serial clock (asynchronous) |
| mosiIn | input | 1 | Controller-to-peripheral data line |
| misoIn | input | 1 | Peripheral-to-controller data line |
| csIn | input | 1 | Chip-select line |
| cfgCpol | input | 1 | Idle level of SCK |
| cfgCpha | input | 1 | 0: capture on leading edge, 1: on trailing edge |
| cfgCsActiveHigh | input | 1 | Chip-select active level |
| cfgLsbFirst | input | 1 | 1: first bit is the word LSB |
| cfgWordSize | input | $clog2(MAX_WORD+1) | Bits per word; 0 or above MAX_WORD means MAX_WORD |
| cfgMosiPresent | input | 1 | MOSI lane is wired |
| cfgMisoPresent | input | 1 | MISO lane is wired |
| cfgCsPresent | input | 1 | Chip-select line is wired |
| wordValid | output | 1 | One-cycle strobe for a completed word |
| wordMosi | output | MAX_WORD | MOSI word value |
| wordMiso | output | MAX_WORD | MISO word value |
| wordMosiPresent | output | 1 | MOSI lane was present for this word |
| wordMisoPresent | output | 1 | MISO lane was present for this word |
| wordWarn | output | 1 | Framing warning for this word |
| wordSpan | output | SPAN_W | First-to-last sample distance plus one |
| csChangeValid | output | 1 | One-cycle strobe on a chip-select change |
| csOldLevel | output | 1 | Pin level before the change |
| csNewLevel | output | 1 | Pin level after the change |
| xferStart | output | 1 | One-cycle strobe on chip-select activation |
| xferEnd | output | 1 | One-cycle strobe on chip-select release |
| xferWordCount | output | CNT_W | Words completed in the transfer just ended |

## Verification
Every pin change takes three clock edges to reach an output: two synchronizer flops plus the output register. The bench logs the cycle in which it drives the SCK edge that carries the last bit, and requires wordValid exactly three cycles later. Words and strobes are captured on falling clock edges into logs, and each log is compared only after the bus has stayed idle for at least eight cycles. So no check depends on where a result lands inside the bit period. Because the bench holds each SCK level for four cycles, the expected span is eight cycles per bit plus one.

// File: rtl/spimon_pkg.sv
package spimon_pkg;
  // Strobes from the edge/framing control to the word datapath.
  typedef struct packed {
    logic takeBit;    // capture one bit on both lanes this cycle
    logic firstBit;   // the captured bit opens a new word
    logic lastBit;    // the captured bit closes the word
    logic clearWord;  // chip-select edge: drop any partial word
    logic csOff;      // chip select is inactive after this cycle
  } wordCtl_t;
endpackage

// File: rtl/spimon_sync.sv
module spimon_sync #(
  parameter int LINES = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LINES-1:0] pinIn,
  output logic [LINES-1:0] lvlNow,
  output logic             settled
);
  logic [LINES-1:0] meta;
  logic [1:0]       warm;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      meta   <= '0;
      lvlNow <= '0;
      warm   <= '0;
    end else begin
      meta   <= pinIn;
      lvlNow <= meta;
      if (warm != 2'd3) warm <= warm + 2'd1;
    end
  end

  // Edges count only once the chain and the edge register hold real pin data.
  assign settled = (warm == 2'd3);
endmodule

// File: rtl/spimon_ctrl.sv
module spimon_ctrl
  import spimon_pkg::*;
#(
  parameter int MAX_WORD = 32,
  parameter int CNT_W    = 16,
  localparam int WSW     = $clog2(MAX_WORD + 1)
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           settled,
  input  logic           sck,
  input  logic           cs,
  input  logic           cfgCpol,
  input  logic           cfgCpha,
  input  logic           cfgCsActiveHigh,
  input  logic           cfgLsbFirst,
  input  logic [WSW-1:0] cfgWordSize,
  input  logic           cfgMosiPresent,
  input  logic           cfgMisoPresent,
  input  logic           cfgCsPresent,
  output wordCtl_t       ctl,
  output logic [WSW-1:0] bitPos,
  output logic           csChangeValid,
  output logic           csOldLevel,
  output logic           csNewLevel,
  output logic           xferStart,
  output logic           xferEnd,
  output logic [CNT_W-1:0] xferWordCount
);
  localparam logic [WSW-1:0] MAXW = WSW'(MAX_WORD);

  logic           sckD, csD;
  logic [WSW-1:0] bitCnt, idxEff, effSize;
  logic [CNT_W-1:0] wordsSoFar, wordsNext;
  logic sckRise, sckFall, sampleEdge;
  logic csWasActive, csIsActive, csEdge, csAssertEdge, csReleaseEdge;
  logic takeBit, lastBit;

  always_comb begin
    effSize = ((cfgWordSize == '0) || (cfgWordSize > MAXW)) ? MAXW : cfgWordSize;
    sckRise = settled & sck & ~sckD;
    sckFall = settled & ~sck & sckD;
    // Equal polarity and phase capture on rising edges, unequal on falling.
    sampleEdge = (cfgCpol ^ cfgCpha) ? sckFall : sckRise;
    csWasActive = cfgCsPresent ? (csD == cfgCsActiveHigh) : 1'b1;
    csIsActive  = cfgCsPresent ? (cs  == cfgCsActiveHigh) : 1'b1;
    csEdge        = settled & cfgCsPresent & (cs ^ csD);
    csAssertEdge  = csEdge & csIsActive;
    csReleaseEdge = csEdge & ~csIsActive;
    takeBit = sampleEdge & csWasActive & (cfgMosiPresent | cfgMisoPresent);
    idxEff  = csEdge ? '0 : bitCnt;
    lastBit = takeBit & (idxEff == effSize - WSW'(1));
    bitPos  = cfgLsbFirst ? idxEff : WSW'(effSize - WSW'(1) - idxEff);
    wordsNext = (lastBit && (wordsSoFar != '1)) ? wordsSoFar + CNT_W'(1) : wordsSoFar;

    ctl.takeBit   = takeBit;
    ctl.firstBit  = takeBit & (idxEff == '0);
    ctl.lastBit   = lastBit;
    ctl.clearWord = csEdge;
    ctl.csOff     = ~csIsActive;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckD          <= 1'b0;
      csD           <= 1'b0;
      bitCnt        <= '0;
      wordsSoFar    <= '0;
      csChangeValid <= 1'b0;
      csOldLevel    <= 1'b0;
      csNewLevel    <= 1'b0;
      xferStart     <= 1'b0;
      xferEnd       <= 1'b0;
      xferWordCount <= '0;
    end else begin
      sckD <= sck;
      csD  <= cs;
      if (takeBit)     bitCnt <= lastBit ? '0 : idxEff + WSW'(1);
      else if (csEdge) bitCnt <= '0;

      if (csAssertEdge) wordsSoFar <= '0;
      else              wordsSoFar <= wordsNext;

      csChangeValid <= csEdge;
      xferStart     <= csAssertEdge;
      xferEnd       <= csReleaseEdge;
      if (csEdge) begin
        csOldLevel <= csD;
        csNewLevel <= cs;
      end
      if (csReleaseEdge) xferWordCount <= wordsNext;
    end
  end
endmodule

// File: rtl/spimon_datapath.sv
module spimon_datapath
  import spimon_pkg::*;
#(
  parameter int MAX_WORD = 32,
  parameter int SPAN_W   = 16,
  localparam int WSW     = $clog2(MAX_WORD + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  wordCtl_t            ctl,
  input  logic [WSW-1:0]      bitPos,
  input  logic                mosi,
  input  logic                miso,
  input  logic                cfgMosiPresent,
  input  logic                cfgMisoPresent,
  output logic                wordValid,
  output logic [MAX_WORD-1:0] wordMosi,
  output logic [MAX_WORD-1:0] wordMiso,
  output logic                wordMosiPresent,
  output logic                wordMisoPresent,
  output logic                wordWarn,
  output logic [SPAN_W-1:0]   wordSpan
);
  logic [MAX_WORD-1:0] shMosi, shMiso, nextMosi, nextMiso, oneMosi, oneMiso;
  logic [SPAN_W-1:0]   spanCnt, spanInc, spanOut;
  logic                wordOpen, warnHold, warnNow;

  always_comb begin
    oneMosi  = {{(MAX_WORD-1){1'b0}}, mosi & cfgMosiPresent} << bitPos;
    oneMiso  = {{(MAX_WORD-1){1'b0}}, miso & cfgMisoPresent} << bitPos;
    nextMosi = (ctl.firstBit ? '0 : shMosi) | oneMosi;
    nextMiso = (ctl.firstBit ? '0 : shMiso) | oneMiso;
    spanInc  = (spanCnt == '1) ? spanCnt : spanCnt + SPAN_W'(1);
    spanOut  = ctl.firstBit ? SPAN_W'(1) : spanInc;
    warnNow  = ctl.firstBit ? ctl.csOff : warnHold;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shMosi <= '0; shMiso <= '0;
      spanCnt <= '0; wordOpen <= 1'b0; warnHold <= 1'b0;
      wordValid <= 1'b0; wordMosi <= '0; wordMiso <= '0;
      wordMosiPresent <= 1'b0; wordMisoPresent <= 1'b0;
      wordWarn <= 1'b0; wordSpan <= '0;
    end else begin
      wordValid <= ctl.lastBit;
      if (ctl.takeBit) begin
        warnHold <= warnNow;
        if (ctl.lastBit) begin
          shMosi <= '0; shMiso <= '0;
          spanCnt <= '0; wordOpen <= 1'b0;
          wordMosi <= nextMosi;
          wordMiso <= nextMiso;
          wordMosiPresent <= cfgMosiPresent;
          wordMisoPresent <= cfgMisoPresent;
          wordWarn <= warnNow;
          wordSpan <= spanOut;
        end else begin
          shMosi <= nextMosi; shMiso <= nextMiso;
          spanCnt <= spanOut; wordOpen <= 1'b1;
        end
      end else if (ctl.clearWord) begin
        shMosi <= '0; shMiso <= '0;
        spanCnt <= '0; wordOpen <= 1'b0;
      end else if (wordOpen) begin
        spanCnt <= spanInc;
      end
    end
  end
endmodule

// File: rtl/spi_bus_monitor.sv
module spi_bus_monitor
  import spimon_pkg::*;
#(
  parameter int MAX_WORD = 32,
  parameter int SPAN_W   = 16,
  parameter int CNT_W    = 16,
  localparam int WSW     = $clog2(MAX_WORD + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sckIn,
  input  logic                mosiIn,
  input  logic                misoIn,
  input  logic                csIn,
  input  logic                cfgCpol,
  input  logic                cfgCpha,
  input  logic                cfgCsActiveHigh,
  input  logic                cfgLsbFirst,
  input  logic [WSW-1:0]      cfgWordSize,
  input  logic                cfgMosiPresent,
  input  logic                cfgMisoPresent,
  input  logic                cfgCsPresent,
  output logic                wordValid,
  output logic [MAX_WORD-1:0] wordMosi,
  output logic [MAX_WORD-1:0] wordMiso,
  output logic                wordMosiPresent,
  output logic                wordMisoPresent,
  output logic                wordWarn,
  output logic [SPAN_W-1:0]   wordSpan,
  output logic                csChangeValid,
  output logic                csOldLevel,
  output logic                csNewLevel,
  output logic                xferStart,
  output logic                xferEnd,
  output logic [CNT_W-1:0]    xferWordCount
);
  logic [3:0]     lvl;
  logic           settled;
  wordCtl_t       ctl;
  logic [WSW-1:0] bitPos;

  spimon_sync #(.LINES(4)) u_sync (
    .clk(clk), .rstN(rstN),
    .pinIn({csIn, misoIn, mosiIn, sckIn}),
    .lvlNow(lvl), .settled(settled)
  );

  spimon_ctrl #(.MAX_WORD(MAX_WORD), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .settled(settled),
    .sck(lvl[0]), .cs(lvl[3]),
    .cfgCpol(cfgCpol), .cfgCpha(cfgCpha), .cfgCsActiveHigh(cfgCsActiveHigh),
    .cfgLsbFirst(cfgLsbFirst), .cfgWordSize(cfgWordSize),
    .cfgMosiPresent(cfgMosiPresent), .cfgMisoPresent(cfgMisoPresent),
    .cfgCsPresent(cfgCsPresent),
    .ctl(ctl), .bitPos(bitPos),
    .csChangeValid(csChangeValid), .csOldLevel(csOldLevel), .csNewLevel(csNewLevel),
    .xferStart(xferStart), .xferEnd(xferEnd), .xferWordCount(xferWordCount)
  );

  spimon_datapath #(.MAX_WORD(MAX_WORD), .SPAN_W(SPAN_W)) u_data (
    .clk(clk), .rstN(rstN), .ctl(ctl), .bitPos(bitPos),
    .mosi(lvl[1]), .miso(lvl[2]),
    .cfgMosiPresent(cfgMosiPresent), .cfgMisoPresent(cfgMisoPresent),
    .wordValid(wordValid), .wordMosi(wordMosi), .wordMiso(wordMiso),
    .wordMosiPresent(wordMosiPresent), .wordMisoPresent(wordMisoPresent),
    .wordWarn(wordWarn), .wordSpan(wordSpan)
  );
endmodule

// File: rtl/spimon_checker.sv
module spimon_checker #(
  parameter int MAX_WORD = 32,
  parameter int SPAN_W   = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic                cfgCsPresent,
  input logic                wordValid,
  input logic [MAX_WORD-1:0] wordMosi,
  input logic [MAX_WORD-1:0] wordMiso,
  input logic                wordMosiPresent,
  input logic                wordMisoPresent,
  input logic [SPAN_W-1:0]   wordSpan,
  input logic                csChangeValid,
  input logic                csOldLevel,
  input logic                csNewLevel,
  input logic                xferEnd
);
  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |=> !wordValid);
  a_r11_hold_word: assert property (@(posedge clk) disable iff (!rstN)
    !wordValid |-> ($stable(wordMosi) && $stable(wordMiso) && $stable(wordSpan)));
  a_r6_levels_differ: assert property (@(posedge clk) disable iff (!rstN)
    csChangeValid |-> (csOldLevel != csNewLevel));
  a_r6_no_cs_events: assert property (@(posedge clk) disable iff (!rstN)
    !cfgCsPresent |-> !csChangeValid);
  a_r7_end_on_change: assert property (@(posedge clk) disable iff (!rstN)
    xferEnd |-> csChangeValid);
  a_r9_absent_mosi_zero: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && !wordMosiPresent) |-> (wordMosi == '0));
  a_r9_absent_miso_zero: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && !wordMisoPresent) |-> (wordMiso == '0));
  a_r10_span_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |-> (wordSpan != '0));
endmodule

bind spi_bus_monitor spimon_checker #(.MAX_WORD(MAX_WORD), .SPAN_W(SPAN_W)) u_chk (
  .clk(clk), .rstN(rstN), .cfgCsPresent(cfgCsPresent),
  .wordValid(wordValid), .wordMosi(wordMosi), .wordMiso(wordMiso),
  .wordMosiPresent(wordMosiPresent), .wordMisoPresent(wordMisoPresent),
  .wordSpan(wordSpan), .csChangeValid(csChangeValid),
  .csOldLevel(csOldLevel), .csNewLevel(csNewLevel), .xferEnd(xferEnd)
);

// File: tb/spi_bus_monitor_bench.sv
module spi_bus_monitor_bench;
  localparam int MAXW = 32, SPANW = 16, CNTW = 16, WSW = 6, Q = 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN, sckIn, mosiIn, misoIn, csIn;
  logic cfgCpol, cfgCpha, cfgCsActiveHigh, cfgLsbFirst;
  logic [WSW-1:0] cfgWordSize;
  logic cfgMosiPresent, cfgMisoPresent, cfgCsPresent;
  logic wordValid, wordMosiPresent, wordMisoPresent, wordWarn;
  logic [MAXW-1:0] wordMosi, wordMiso;
  logic [SPANW-1:0] wordSpan;
  logic csChangeValid, csOldLevel, csNewLevel, xferStart, xferEnd;
  logic [CNTW-1:0] xferWordCount;

  spi_bus_monitor u_spi_bus_monitor (.*);

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, failures = 0;
  // Logs filled by the monitor on falling edges.
  int nW = 0, nCs = 0, nStart = 0, nEnd = 0, lastCount = 0;
  logic lastOld, lastNew, prevWv = 1'b0;
  logic [MAXW-1:0] gM [0:255];
  logic [MAXW-1:0] gS [0:255];
  logic gWarn [0:255];
  logic gMP [0:255];
  logic gSP [0:255];
  int gSpan [0:255];
  int gCyc [0:255];
  int lastSampleCyc = 0;
  logic [MAXW-1:0] txM [0:7];
  logic [MAXW-1:0] txS [0:7];
  int expCyc [0:7];

  always @(negedge clk) begin
    if (wordValid && nW < 256) begin
      gM[nW] = wordMosi; gS[nW] = wordMiso; gWarn[nW] = wordWarn;
      gMP[nW] = wordMosiPresent; gSP[nW] = wordMisoPresent;
      gSpan[nW] = int'(wordSpan); gCyc[nW] = cyc; nW++;
    end
    if (wordValid && prevWv) begin
      checks++; failures++;
      $display("FAIL R11 wordValid longer than one cycle actual=2 expected=1");
    end
    prevWv = wordValid;
    if (csChangeValid) begin nCs++; lastOld = csOldLevel; lastNew = csNewLevel; end
    if (xferStart) nStart++;
    if (xferEnd) begin nEnd++; lastCount = int'(xferWordCount); end
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [MAXW-1:0] maskTo(input logic [MAXW-1:0] v, input int ws);
    return (ws >= MAXW) ? v : (v & ((MAXW'(1) << ws) - 1));
  endfunction

  function automatic logic [MAXW-1:0] bitRev(input logic [MAXW-1:0] v, input int ws);
    logic [MAXW-1:0] r = '0;
    for (int i = 0; i < ws; i++) r[i] = v[ws-1-i];
    return r;
  endfunction

  // Send ws bits on the wire; wireLsb picks which end of the value goes first.
  task automatic sendBits(input logic [MAXW-1:0] mv, input logic [MAXW-1:0] sv,
                          input int ws, input bit wireLsb);
    for (int n = 0; n < ws; n++) begin
      int idx = wireLsb ? n : ws - 1 - n;
      mosiIn = mv[idx]; misoIn = sv[idx];
      idle(Q);
      sckIn = ~sckIn; if (!cfgCpha) lastSampleCyc = cyc;
      idle(2 * Q);
      sckIn = ~sckIn; if (cfgCpha) lastSampleCyc = cyc;
      idle(Q);
    end
  endtask

  function automatic logic csActiveLvl();
    return cfgCsActiveHigh;
  endfunction

  task automatic setMode(input bit pol, input bit pha);
    csIn = ~csActiveLvl(); idle(2);
    cfgCpol = pol; cfgCpha = pha; sckIn = pol; idle(8);
  endtask

  // One transfer of nw words; words are sent in the configured order.
  task automatic doXfer(input int nw, input int ws, input string req);
    int base = nW, e0 = nEnd;
    int effWs = (ws == 0 || ws > MAXW) ? MAXW : ws;
    csIn = csActiveLvl(); idle(6);
    for (int k = 0; k < nw; k++) begin
      sendBits(txM[k], txS[k], effWs, cfgLsbFirst);
      expCyc[k] = lastSampleCyc + 3;
    end
    idle(4); csIn = ~csActiveLvl(); idle(10);
    chk(req, "word count", nW - base, nw);
    for (int k = 0; k < nw && base + k < nW; k++) begin
      chk(req, "mosi", gM[base+k], cfgMosiPresent ? maskTo(txM[k], effWs) : 0);
      chk(req, "miso", gS[base+k], cfgMisoPresent ? maskTo(txS[k], effWs) : 0);
      chk("R10", "span", gSpan[base+k], (effWs - 1) * 4 * Q + 1);
      chk("R8", "warn clear", gWarn[base+k], 0);
      chk("R11", "latency", gCyc[base+k], expCyc[k]);
    end
    if (cfgCsPresent) begin
      chk("R7", "xfer end", nEnd - e0, 1);
      chk("R7", "xfer count", lastCount, nw);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=hang expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int base, c0, s0, e0, sd;
    sd = $urandom(32'h5A17);
    rstN = 1'b0; sckIn = 1'b0; mosiIn = 1'b0; misoIn = 1'b0; csIn = 1'b1;
    cfgCpol = 0; cfgCpha = 0; cfgCsActiveHigh = 0; cfgLsbFirst = 0;
    cfgWordSize = 6'd8; cfgMosiPresent = 1; cfgMisoPresent = 1; cfgCsPresent = 1;
    idle(5); rstN = 1'b1; idle(10);

    // Reset state
    chk("R11", "reset wordValid", wordValid, 0);
    chk("R11", "reset wordMosi", wordMosi, 0);
    chk("R6", "reset csChange", nCs, 0);
    chk("R7", "reset xferEnd", nEnd, 0);

    // Directed mode (0,0), MSB first, with chip-select event levels
    c0 = nCs;
    txM[0] = 32'hA5; txS[0] = 32'h3C;
    csIn = 0; idle(6);
    chk("R6", "assert event", nCs - c0, 1);
    chk("R6", "assert old", lastOld, 1);
    chk("R6", "assert new", lastNew, 0);
    chk("R7", "xfer start", nStart, 1);
    csIn = 1; idle(10);
    chk("R6", "release new", lastNew, 1);
    chk("R7", "empty xfer count", lastCount, 0);
    doXfer(1, 8, "R1");

    // Bit order: wire MSB-first value 0xC0 read back LSB-first
    cfgLsbFirst = 1; base = nW;
    csIn = 0; idle(6); sendBits(32'hC0, 32'h81, 8, 1'b0); idle(4); csIn = 1; idle(10);
    chk("R3", "lsb count", nW - base, 1);
    chk("R3", "lsb mosi", gM[base], bitRev(32'hC0, 8));
    chk("R3", "lsb miso", gS[base], bitRev(32'h81, 8));
    cfgLsbFirst = 0;

    // Random modes, orders, sizes and word counts
    for (int it = 0; it < 14; it++) begin
      int ws = 1 + int'($urandom % 32);
      int nw = 1 + int'($urandom % 3);
      setMode(1'($urandom), 1'($urandom));
      cfgLsbFirst = 1'($urandom);
      cfgWordSize = WSW'(ws);
      for (int k = 0; k < nw; k++) begin txM[k] = $urandom; txS[k] = $urandom; end
      doXfer(nw, ws, (cfgCpol ^ cfgCpha) ? "R1 fall" : "R1 rise");
    end

    // Size clamp: 0 and 40 both mean 32
    setMode(0, 0); cfgLsbFirst = 0;
    cfgWordSize = 6'd0; txM[0] = 32'hDEADBEEF; txS[0] = 32'h12345678;
    doXfer(1, 0, "R4 size0");
    cfgWordSize = 6'd40; txM[0] = 32'h0F0F1234; txS[0] = 32'hFFFF0001;
    doXfer(1, 40, "R4 size40");

    // Partial word dropped by chip-select release
    cfgWordSize = 6'd8; base = nW;
    csIn = 0; idle(6); sendBits(32'h1F, 32'h1F, 5, 1'b0); idle(4); csIn = 1; idle(10);
    chk("R5", "partial dropped", nW - base, 0);
    chk("R5", "partial count", lastCount, 0);
    txM[0] = 32'h5A; txS[0] = 32'hC3;
    doXfer(1, 8, "R5 after partial");

    // Inactive chip select ignores SCK; then active-high polarity
    base = nW;
    sendBits(32'hFF, 32'hFF, 8, 1'b0); idle(10);
    chk("R2", "inactive ignored", nW - base, 0);
    cfgCsActiveHigh = 1; csIn = 0; idle(10);
    c0 = nCs;
    txM[0] = 32'h96; txS[0] = 32'h69;
    doXfer(1, 8, "R2 active-high");
    chk("R2", "active-high events", nCs - c0, 2);
    cfgCsActiveHigh = 0; csIn = 1; idle(10);

    // No chip-select line: always selected, no events
    cfgCsPresent = 0; c0 = nCs; s0 = nStart; e0 = nEnd; base = nW;
    csIn = 1; sendBits(32'h3E, 32'h71, 8, 1'b0); csIn = 0; idle(4); csIn = 1; idle(10);
    chk("R6", "no-cs word", nW - base, 1);
    chk("R6", "no-cs value", gM[base], 32'h3E);
    chk("R6", "no-cs events", nCs - c0, 0);
    chk("R7", "no-cs xfer", (nStart - s0) + (nEnd - e0), 0);
    chk("R8", "no-cs warn", gWarn[base], 0);
    cfgCsPresent = 1; idle(6);

    // Absent MISO lane, then both lanes absent
    cfgMisoPresent = 0; txM[0] = 32'hB4; txS[0] = 32'hFF;
    doXfer(1, 8, "R9 miso absent");
    chk("R9", "miso flag", gSP[nW-1], 0);
    chk("R9", "mosi flag", gMP[nW-1], 1);
    cfgMosiPresent = 0; base = nW;
    csIn = 0; idle(6); sendBits(32'hFF, 32'hFF, 8, 1'b0); idle(4); csIn = 1; idle(10);
    chk("R9", "no lanes no word", nW - base, 0);
    cfgMosiPresent = 1; cfgMisoPresent = 1;

    // Framing warning: first bit captured as chip select releases
    cfgWordSize = 6'd1; base = nW; e0 = nEnd;
    csIn = 0; idle(6);
    mosiIn = 1; misoIn = 0; idle(Q);
    sckIn = 1; csIn = 1; lastSampleCyc = cyc; idle(2 * Q);
    sckIn = 0; idle(10);
    chk("R8", "warn word", nW - base, 1);
    chk("R8", "warn flag", gWarn[base], 1);
    chk("R8", "warn mosi", gM[base], 1);
    chk("R10", "span one bit", gSpan[base], 1);
    chk("R7", "warn xfer count", lastCount, 1);
    chk("R7", "warn xfer end", nEnd - e0, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule